// File: doc/BRIEF.md
# Hot-Plug Slot Command Completion Controller

This block holds the slot control and slot status registers of a downstream port that supports hot-plug. Configuration software reaches both through one 32-bit configuration access port with byte enables. A write to the control half may count as a hot-plug command. When it does, the block forwards the six control bits to an external power and indicator controller over a valid/ready handshake. When that controller accepts the command, the block sets a Command Completed status bit and may raise an interrupt pulse.

A parameter selects how writes become commands. In strict mode, every write to the control half is a command. In change-only mode, a write is a command only when it alters one of the indicator, power or interlock control fields. A write that only touches the notification enables produces nothing in that mode. A port whose hot-plug capable input is low never produces a command. One further command can wait in a holding slot while the handshake is stalled.

Top module: `slot_cmd_ctrl`

## Requirements
- R1: The slot registers are read and written as one dword at byte address A8h. Bits 15:0 hold the control register and bits 31:16 hold the status register. Command Completed is dword bit 20 (status bit 4), and every other status bit reads 0. After reset, both registers read 0 and `cmd_valid` is low.
- R2: A write changes control bits 7:0 only when `cfg_be[0]` is set, and bits 15:8 only when `cfg_be[1]` is set. All other bits keep their value.
- R3: In strict mode, on a capable port, every write with `cfg_be[0]` or `cfg_be[1]` set at A8h issues a command. The command carries the new control bits 11:6 on `cmd_ctrl`.
- R4: In change-only mode, a write issues a command only if the written bytes alter control bits 11:6: interlock (11), power (10), power indicator (9:8) or attention indicator (7:6). A write that only changes other bits, such as the enables in bits 5:4, issues nothing.
- R5: While `hp_capable` is low, no write issues a command.
- R6: Once raised, `cmd_valid` and `cmd_ctrl` hold steady until a cycle with `cmd_ready` high.
- R7: While a command waits, the next command goes into a single holding slot and is presented right after the waiting one is accepted. A further command that arrives while the slot is full replaces the held one.
- R8: Command Completed becomes 1 in the cycle after a handshake cycle (`cmd_valid` and `cmd_ready` both high). A write at A8h with `cfg_be[2]` set and data bit 20 set clears it. Data bit 20 at 0 leaves it alone. A clear and a set in the same cycle leave it at 1.
- R9: `irq` pulses high for exactly one cycle when Command Completed goes from 0 to 1 while control bits 4 and 5 are both 1.
- R10: `cfg_rdata` is registered. It shows the register dword one cycle after `cfg_rd` at A8h, and 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_capable | input | 1 | Port supports hot-plug |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Byte address of the dword |
| cfg_be | input | 4 | Byte enables for write data |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| cmd_valid | output | 1 | Command presented to slot controller |
| cmd_ready | input | 1 | Slot controller accepts command |
| cmd_ctrl | output | 6 | Control bits 11:6 of the command |
| irq | output | 1 | Command-completed interrupt pulse |

## Verification
The checker watches every cycle for four things: that a stalled command keeps its value, that a command rises only after the capable input was high, that Command Completed rises only after a handshake, and that the interrupt is a single-cycle pulse tied to that rise with both enables set. Several properties only show in the bench scenarios: whether a given write counts as a command in each mode, the byte-enable merge, the order in which held commands drain, and set-over-clear on the status bit. For these, the bench runs a strict instance and a change-only instance side by side against a behavioural model.

// File: rtl/slot_cmd_pkg.sv
package slot_cmd_pkg;
  typedef enum logic {MODE_STRICT = 1'b0, MODE_CHANGE = 1'b1} cmd_mode_e;
  localparam int CTRL_W   = 16;
  localparam int FIELD_LO = 6;
  localparam int FIELD_HI = 11;
  localparam int FIELD_W  = FIELD_HI - FIELD_LO + 1;
  localparam int CC_BIT   = 4;
  localparam int CCIE_BIT = 4;
  localparam int HPIE_BIT = 5;
  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/slot_cmd_detect.sv
module slot_cmd_detect import slot_cmd_pkg::*; #(
  parameter cmd_mode_e MODE = MODE_STRICT
) (
  input  logic [CTRL_W-1:0] old_ctrl,
  input  logic [CTRL_W-1:0] new_ctrl,
  input  logic              ctrl_write,
  input  logic              hp_capable,
  output logic              is_cmd
);
  logic qualifies;
  generate
    if (MODE == MODE_CHANGE) begin : g_change
      assign qualifies = |(old_ctrl[FIELD_HI:FIELD_LO] ^ new_ctrl[FIELD_HI:FIELD_LO]);
    end else begin : g_strict
      assign qualifies = 1'b1;
    end
  endgenerate
  assign is_cmd = ctrl_write & hp_capable & qualifies;
endmodule

// File: rtl/slot_cmd_queue.sv
module slot_cmd_queue #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  logic         hold_v;
  logic [W-1:0] hold_d;
  logic         fire;
  assign fire = valid & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      hold_v <= 1'b0;
      data   <= '0;
      hold_d <= '0;
    end else if (fire) begin
      if (hold_v) begin
        data   <= hold_d;
        hold_v <= push;
        if (push) hold_d <= push_data;
      end else begin
        valid <= push;
        if (push) data <= push_data;
      end
    end else if (!valid) begin
      valid <= push;
      if (push) data <= push_data;
    end else if (push) begin
      hold_v <= 1'b1;
      hold_d <= push_data;
    end
  end
endmodule

// File: rtl/slot_cmd_status.sv
module slot_cmd_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_both,
  output logic cc_o,
  output logic irq_o
);
  logic cc_n;
  assign cc_n = set_i | (cc_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_o  <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      cc_o  <= cc_n;
      irq_o <= cc_n & ~cc_o & ie_both;
    end
  end
endmodule

// File: rtl/slot_cmd_ctrl.sv
module slot_cmd_ctrl import slot_cmd_pkg::*; #(
  parameter cmd_mode_e        MODE      = MODE_STRICT,
  parameter int               ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] SLOT_ADDR = 12'h0A8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hp_capable,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [FIELD_W-1:0] cmd_ctrl,
  output logic              irq
);
  localparam int BYTES = CTRL_W / 8;

  logic              hit;
  logic              ctrl_we;
  logic              cc_clr;
  logic              is_cmd;
  logic              cc_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_new;
  logic [CTRL_W-1:0] status_w;

  assign hit     = (cfg_addr == SLOT_ADDR);
  assign ctrl_we = cfg_wr & hit & (|cfg_be[BYTES-1:0]);
  assign cc_clr  = cfg_wr & hit & cfg_be[2] & cfg_wdata[CTRL_W + CC_BIT];

  genvar b;
  generate
    for (b = 0; b < BYTES; b++) begin : g_byte
      assign ctrl_new[8*b +: 8] = cfg_be[b] ? cfg_wdata[8*b +: 8] : ctrl_q[8*b +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_new;
  end

  slot_cmd_detect #(.MODE(MODE)) u_detect (
    .old_ctrl   (ctrl_q),
    .new_ctrl   (ctrl_new),
    .ctrl_write (ctrl_we),
    .hp_capable (hp_capable),
    .is_cmd     (is_cmd)
  );

  slot_cmd_queue #(.W(FIELD_W)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (is_cmd),
    .push_data (ctrl_new[FIELD_HI:FIELD_LO]),
    .ready     (cmd_ready),
    .valid     (cmd_valid),
    .data      (cmd_ctrl)
  );

  slot_cmd_status u_status (
    .clk     (clk),
    .rst     (rst),
    .set_i   (cmd_valid & cmd_ready),
    .clr_i   (cc_clr),
    .ie_both (ctrl_q[CCIE_BIT] & ctrl_q[HPIE_BIT]),
    .cc_o    (cc_q),
    .irq_o   (irq)
  );

  assign status_w = CTRL_W'({cc_q}) << CC_BIT;

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (cfg_rd & hit) cfg_rdata <= {status_w, ctrl_q};
    else cfg_rdata <= '0;
  end
endmodule

// File: rtl/slot_cmd_chk.sv
module slot_cmd_chk (
  input logic        clk,
  input logic        rst,
  input logic        hp_capable,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [5:0]  cmd_ctrl,
  input logic        irq,
  input logic        cc,
  input logic [15:0] ctrl
);
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_ctrl));
  a_r5_capable_src: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(hp_capable));
  a_r8_set_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(cc) |-> $past(cmd_valid && cmd_ready));
  a_r9_irq_edge: assert property (@(posedge clk) disable iff (rst)
    irq |-> $rose(cc) && $past(ctrl[4] && ctrl[5]));
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind slot_cmd_ctrl slot_cmd_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .hp_capable (hp_capable),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_ctrl   (cmd_ctrl),
  .irq        (irq),
  .cc         (cc_q),
  .ctrl       (ctrl_q)
);

// File: tb/tb_slot_cmd_ctrl.sv
module tb_slot_cmd_ctrl;
  import slot_cmd_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hp_capable = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [11:0] cfg_addr = 12'h0A8;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic        cmd_ready = 1'b0;

  logic [31:0] rd_s, rd_l;
  logic        v_s, v_l, irq_s, irq_l;
  logic [5:0]  c_s, c_l;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slot_cmd_ctrl #(.MODE(MODE_STRICT)) dut (
    .clk(clk), .rst(rst), .hp_capable(hp_capable), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_s),
    .cmd_valid(v_s), .cmd_ready(cmd_ready), .cmd_ctrl(c_s), .irq(irq_s));

  slot_cmd_ctrl #(.MODE(MODE_CHANGE)) dut_lg (
    .clk(clk), .rst(rst), .hp_capable(hp_capable), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_l),
    .cmd_valid(v_l), .cmd_ready(cmd_ready), .cmd_ctrl(c_l), .irq(irq_l));

  // Behavioural reference, one state set per mode (0 strict, 1 change-only)
  logic [15:0] m_ctrl [2];
  bit          m_cc   [2];
  int          m_n    [2];
  logic [5:0]  m_q0   [2];
  logic [5:0]  m_q1   [2];
  bit          e_irq  [2];
  logic [31:0] e_rd   [2];

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (rst) begin
        m_ctrl[m] = 16'h0; m_cc[m] = 0; m_n[m] = 0; m_q0[m] = 6'h0; m_q1[m] = 6'h0;
        e_irq[m] = 0; e_rd[m] = 32'h0;
      end else begin
        bit hitw, fire, clr, newcmd, ccn;
        logic [15:0] nc;
        hitw = cfg_wr && cfg_addr == 12'h0A8;
        nc = m_ctrl[m];
        if (cfg_be[0]) nc[7:0] = cfg_wdata[7:0];
        if (cfg_be[1]) nc[15:8] = cfg_wdata[15:8];
        fire = (m_n[m] > 0) && cmd_ready;
        clr = hitw && cfg_be[2] && cfg_wdata[20];
        newcmd = hitw && (cfg_be[0] || cfg_be[1]) && hp_capable &&
                 (m == 0 || nc[11:6] != m_ctrl[m][11:6]);
        e_rd[m] = (cfg_rd && cfg_addr == 12'h0A8) ?
                  {11'h0, m_cc[m], 4'h0, m_ctrl[m]} : 32'h0;
        ccn = fire || (m_cc[m] && !clr);
        e_irq[m] = ccn && !m_cc[m] && m_ctrl[m][4] && m_ctrl[m][5];
        m_cc[m] = ccn;
        if (hitw && (cfg_be[0] || cfg_be[1])) m_ctrl[m] = nc;
        if (fire) begin m_q0[m] = m_q1[m]; m_n[m]--; end
        if (newcmd) begin
          if (m_n[m] == 0) begin m_q0[m] = nc[11:6]; m_n[m] = 1; end
          else begin m_q1[m] = nc[11:6]; m_n[m] = 2; end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 valid strict", 32'(v_s), 32'(m_n[0] > 0));
      chk("R6 valid change", 32'(v_l), 32'(m_n[1] > 0));
      if (m_n[0] > 0) chk("R3 cmd strict", 32'(c_s), 32'(m_q0[0]));
      if (m_n[1] > 0) chk("R4 cmd change", 32'(c_l), 32'(m_q0[1]));
      chk("R9 irq strict", 32'(irq_s), 32'(e_irq[0]));
      chk("R9 irq change", 32'(irq_l), 32'(e_irq[1]));
      chk("R10 rdata strict", rd_s, e_rd[0]);
      chk("R10 rdata change", rd_l, e_rd[1]);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd();
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = 12'h0A8;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic rdy_pulse();
    @(negedge clk);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset valid", 32'(v_s | v_l), 32'h0);
    rd();
    chk("R1 reset read", rd_s, 32'h0);
    // R5 non-capable port
    wr(12'h0A8, 32'h0000_0FC0, 4'b0011);
    chk("R5 no cmd strict", 32'(v_s), 32'h0);
    chk("R5 no cmd change", 32'(v_l), 32'h0);
    rd();
    chk("R1 ctrl layout", rd_s, 32'h0000_0FC0);
    // R3 / R4: enable-only write
    hp_capable = 1'b1;
    wr(12'h0A8, 32'h0000_00F0, 4'b0001);
    chk("R3 strict cmd", 32'(v_s), 32'h1);
    chk("R3 strict field", 32'(c_s), 32'h3F);
    chk("R4 enable-only no cmd", 32'(v_l), 32'h0);
    // R8 / R9 completion
    rdy_pulse();
    chk("R9 irq pulse", 32'(irq_s), 32'h1);
    chk("R6 drop after accept", 32'(v_s), 32'h0);
    @(negedge clk);
    chk("R9 irq one cycle", 32'(irq_s), 32'h0);
    rd();
    chk("R8 cc set", rd_s, 32'h0010_0FF0);
    chk("R4 cc stays clear", rd_l, 32'h0000_0FF0);
    wr(12'h0A8, 32'h0000_0000, 4'b0100);
    rd();
    chk("R8 write0 no effect", rd_s, 32'h0010_0FF0);
    wr(12'h0A8, 32'h0010_0000, 4'b0100);
    rd();
    chk("R8 w1c clears", rd_s, 32'h0000_0FF0);
    // R2 byte enables, R4 change fires
    wr(12'h0A8, 32'hFFFF_0300, 4'b0010);
    chk("R4 change fires", 32'(v_l), 32'h1);
    chk("R4 change field", 32'(c_l), 32'h0F);
    rd();
    chk("R2 byte merge", rd_l, 32'h0000_03F0);
    rdy_pulse();
    // R7 holding slot
    wr(12'h0A8, 32'h0000_0040, 4'b0011);
    wr(12'h0A8, 32'h0000_0080, 4'b0011);
    wr(12'h0A8, 32'h0000_00C0, 4'b0011);
    chk("R7 first out", 32'(c_s), 32'h01);
    chk("R7 first out change", 32'(c_l), 32'h01);
    rdy_pulse();
    chk("R7 newest held", 32'(c_s), 32'h03);
    chk("R7 held valid", 32'(v_s), 32'h1);
    rdy_pulse();
    chk("R7 drained", 32'(v_s), 32'h0);
    // R8 set wins over clear in the same cycle
    wr(12'h0A8, 32'h0000_0100, 4'b0011);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 12'h0A8; cfg_wdata = 32'h0010_0000; cfg_be = 4'b0100;
    cmd_ready = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0; cmd_ready = 1'b0;
    rd();
    chk("R8 set beats clear", rd_s, 32'h0010_0100);
    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cfg_wr     = ($urandom_range(0, 2) == 0);
      cfg_rd     = ($urandom_range(0, 3) == 0);
      cfg_addr   = ($urandom_range(0, 7) == 0) ? 12'h0AC : 12'h0A8;
      cfg_be     = 4'($urandom);
      cfg_wdata  = $urandom;
      cmd_ready  = ($urandom_range(0, 2) == 0);
      hp_capable = ($urandom_range(0, 9) != 0);
    end
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule